// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

This block keeps a free-running 48-bit count of sub-second ticks, advanced by a 32.768 kHz tick enable, so that whole seconds are bits 47:15 of the count. Software reaches the count as three 16-bit words on a simple word-addressed register bus. The bus can read the words and can also write them to set the current time. A second set of three words holds a 48-bit compare value with the same layout.

Sometimes a tick moves the count onto the compare value. On that edge the block latches an alarm flag in a status register, and the flag stays set until software writes a one to it. The alarm interrupt output is the flag gated by an enable input. Word reads are combinational and are never latched. A carry between two word reads therefore shows up to software, which reads the words twice and retries when the two passes differ.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset the counter, the compare value and the alarm status are all zero, and alarm_irq is low.
- R2: On each clock edge with tick_en high and no counter word write, the counter increases by one. It wraps from all-ones to zero. With tick_en low and no counter write, it holds.
- R3: With bus_win=0, the counter words are read at byte offsets 0x00, 0x02 and 0x04, holding bits 15:0, 31:16 and 47:32. Reads return the live value with no latching, and a carry propagates across word boundaries. Bit 15 of the word at 0x00 is the one-second bit, so 32768 ticks add one to the seconds value.
- R4: A write with bus_win=0 to a counter word replaces only that word and leaves the other two unchanged. The counter does not advance on the edge of the write, even if tick_en is high.
- R5: With bus_win=0, the compare value is read and written at offsets 0x08, 0x0A and 0x0C, with the same bit layout as the counter.
- R6: When a tick advances the counter to a value equal to the compare value held before that edge, status bit 0 (bus_win=1, offset 0x1E) becomes 1 on the same edge. It then stays 1. Making the two equal through a counter or compare write does not set it.
- R7: A write with bus_win=1 to offset 0x1E clears the status when wdata bit 0 is 1 and has no effect when it is 0. A match on the same edge wins over the clear.
- R8: alarm_irq equals the status bit AND alarm_en.
- R9: Odd offsets and offsets not listed above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| bus_win | input | 1 | Register window select: 0 time/compare, 1 status |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| alarm_en | input | 1 | Alarm interrupt enable |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with its default parameters: a 48-bit counter in three 16-bit words and a 5-bit offset. Because the counter words are writable, presetting them to all-ones brings the full wrap to zero and a carry across all three words within a few cycles. A preset seconds value followed by 32768 ticks checks the one-second bit. Random traffic re-aims the compare value a few ticks ahead of the counter, so matches, set-versus-clear collisions and the enable gate occur many times in a short run.

// File: rtl/ets_pkg.sv
package ets_pkg;
  // Byte offsets inside the time window (bus_win = WIN_TIME)
  localparam int CNT_BASE = 'h00;
  localparam int CMP_BASE = 'h08;
  // Byte offset inside the status window (bus_win = WIN_IRQ)
  localparam int STAT_OFS = 'h1E;
  localparam int STAT_ALARM_BIT = 0;
  // Byte stride between consecutive words
  localparam int WORD_STRIDE = 2;

  typedef enum logic {
    WIN_TIME = 1'b0,
    WIN_IRQ  = 1'b1
  } win_e;
endpackage

// File: rtl/ets_rst_sync.sv
module ets_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/ets_counter.sv
module ets_counter #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  localparam int NW    = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NW-1:0]     wr_mask,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_inc,
  output logic              adv
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             any_wr;

  assign any_wr  = |wr_mask;
  assign adv     = tick_en & ~any_wr;
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign cnt_en  = any_wr | tick_en;

  // Next state: a word write takes priority over the tick.
  always_comb begin
    cnt_d = cnt_q;
    if (any_wr) begin
      for (int i = 0; i < NW; i++) begin
        if (wr_mask[i]) cnt_d[i*WORD_W +: WORD_W] = wdata;
      end
    end else if (tick_en) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ets_compare.sv
module ets_compare #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  localparam int NW    = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW-1:0]     wr_mask,
  input  logic [WORD_W-1:0] wdata,
  input  logic              adv,
  input  logic [CNT_W-1:0]  cnt_inc,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              match
);
  logic [CNT_W-1:0] cmp_d;
  logic             cmp_en;

  assign cmp_en = |wr_mask;
  // Match only on a tick that lands the counter on the held value.
  assign match  = adv & (cnt_inc == cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    for (int i = 0; i < NW; i++) begin
      if (wr_mask[i]) cmp_d[i*WORD_W +: WORD_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end
endmodule

// File: rtl/ets_status.sv
module ets_status (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic alarm_en,
  output logic st_q,
  output logic alarm_irq
);
  logic st_d;
  logic st_en;

  assign st_en = match | clr;

  // Set wins over clear.
  always_comb begin
    st_d = st_q;
    if (match)    st_d = 1'b1;
    else if (clr) st_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 1'b0;
    else if (st_en) st_q <= st_d;
  end

  assign alarm_irq = st_q & alarm_en;
endmodule

// File: rtl/ets_regdec.sv
module ets_regdec
  import ets_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5,
  localparam int NW    = CNT_W / WORD_W
) (
  input  logic              wen,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cmp_q,
  input  logic              st_q,
  output logic [NW-1:0]     cnt_wr,
  output logic [NW-1:0]     cmp_wr,
  output logic              st_clr,
  output logic [WORD_W-1:0] rdata
);
  logic [NW-1:0] cnt_hit;
  logic [NW-1:0] cmp_hit;
  logic          st_hit;
  logic          time_win;

  assign time_win = (win_e'(win) == WIN_TIME);

  for (genvar i = 0; i < NW; i++) begin : g_word
    assign cnt_hit[i] = time_win && (addr == ADDR_W'(CNT_BASE + WORD_STRIDE*i));
    assign cmp_hit[i] = time_win && (addr == ADDR_W'(CMP_BASE + WORD_STRIDE*i));
  end

  assign st_hit = (win_e'(win) == WIN_IRQ) && (addr == ADDR_W'(STAT_OFS));

  assign cnt_wr = wen ? cnt_hit : '0;
  assign cmp_wr = wen ? cmp_hit : '0;
  assign st_clr = wen & st_hit & wdata[STAT_ALARM_BIT];

  // Live read mux, no capture of the counter on access.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NW; i++) begin
      if (cnt_hit[i]) rdata = cnt_q[i*WORD_W +: WORD_W];
      if (cmp_hit[i]) rdata = cmp_q[i*WORD_W +: WORD_W];
    end
    if (st_hit) rdata[STAT_ALARM_BIT] = st_q;
  end
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              alarm_en,
  output logic              alarm_irq
);
  localparam int NW = CNT_W / WORD_W;

  logic             rst_s_n;
  logic [NW-1:0]    cnt_wr;
  logic [NW-1:0]    cmp_wr;
  logic             st_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cmp_q;
  logic             adv;
  logic             match;
  logic             st_q;

  ets_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ets_regdec #(.CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
    .wen    (bus_wen),
    .win    (bus_win),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .cnt_q  (cnt_q),
    .cmp_q  (cmp_q),
    .st_q   (st_q),
    .cnt_wr (cnt_wr),
    .cmp_wr (cmp_wr),
    .st_clr (st_clr),
    .rdata  (bus_rdata)
  );

  ets_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick_en (tick_en),
    .wr_mask (cnt_wr),
    .wdata   (bus_wdata),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc),
    .adv     (adv)
  );

  ets_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_mask (cmp_wr),
    .wdata   (bus_wdata),
    .adv     (adv),
    .cnt_inc (cnt_inc),
    .cmp_q   (cmp_q),
    .match   (match)
  );

  ets_status u_st (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .match     (match),
    .clr       (st_clr),
    .alarm_en  (alarm_en),
    .st_q      (st_q),
    .alarm_irq (alarm_irq)
  );
endmodule

// File: rtl/ets_checker.sv
module ets_checker #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              tick_en,
  input logic              bus_win,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              alarm_en,
  input logic              alarm_irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic              st_q
);
  logic cnt_touch;
  logic clr_req;

  // Any write in the time window at an even offset below the compare base
  assign cnt_touch = bus_wen && !bus_win && !bus_addr[0] &&
                     (bus_addr < ADDR_W'(ets_pkg::CMP_BASE));
  assign clr_req   = bus_wen && bus_win &&
                     (bus_addr == ADDR_W'(ets_pkg::STAT_OFS)) && bus_wdata[0];

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tick_en && !cnt_touch) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!tick_en && !bus_wen) |=> $stable(cnt_q));

  assert_set_on_equal_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(st_q) |-> (cnt_q == cmp_q));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q && !clr_req) |=> st_q);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !alarm_en |-> !alarm_irq);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (alarm_en && st_q) |-> alarm_irq);
endmodule

bind elapsed_alarm_timer ets_checker #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .tick_en   (tick_en),
  .bus_win   (bus_win),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .alarm_en  (alarm_en),
  .alarm_irq (alarm_irq),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .st_q      (st_q)
);

// File: tb/elapsed_alarm_timer_tb.sv
module elapsed_alarm_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        bus_win;
  logic [4:0]  bus_addr;
  logic        bus_wen;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        alarm_en;
  logic        alarm_irq;

  // Reference state computed from the requirements
  logic [47:0] m_cnt;
  logic [47:0] m_cmp;
  logic        m_st;

  int checks;
  int fails;
  bit done;

  elapsed_alarm_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alarm_en  (alarm_en),
    .alarm_irq (alarm_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] exp_rd(input bit win, input logic [4:0] a);
    if (!win) begin
      case (a)
        5'h00: return m_cnt[15:0];
        5'h02: return m_cnt[31:16];
        5'h04: return m_cnt[47:32];
        5'h08: return m_cmp[15:0];
        5'h0A: return m_cmp[31:16];
        5'h0C: return m_cmp[47:32];
        default: return 16'h0000;
      endcase
    end
    return (a == 5'h1E) ? {15'h0000, m_st} : 16'h0000;
  endfunction

  // One clock cycle with the given inputs; the model advances on the same edge.
  task automatic cyc(input bit tk, input bit we, input bit win,
                     input logic [4:0] a, input logic [15:0] d);
    logic [47:0] nc;
    logic [47:0] ncmp;
    logic        nst;
    bit          cw;
    bit          mt;
    tick_en = tk; bus_wen = we; bus_win = win; bus_addr = a; bus_wdata = d;
    nc   = m_cnt;
    ncmp = m_cmp;
    cw   = we && !win && (a == 5'h00 || a == 5'h02 || a == 5'h04);
    if (cw) nc[a[2:1]*16 +: 16] = d;
    else if (tk) nc = m_cnt + 48'd1;
    mt = tk && !cw && ((m_cnt + 48'd1) == m_cmp);
    if (we && !win && (a == 5'h08 || a == 5'h0A || a == 5'h0C))
      ncmp[(a[2:1]-2'd0)*16 +: 16] = d;
    if (mt) nst = 1'b1;
    else if (we && win && a == 5'h1E && d[0]) nst = 1'b0;
    else nst = m_st;
    @(posedge clk);
    m_cnt = nc; m_cmp = ncmp; m_st = nst;
    @(negedge clk);
    tick_en = 1'b0; bus_wen = 1'b0;
  endtask

  task automatic rd_check(input bit win, input logic [4:0] a, input string req);
    logic [15:0] e;
    bus_wen = 1'b0; bus_win = win; bus_addr = a;
    #1;
    e = exp_rd(win, a);
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s read win=%0d off=0x%02h actual=0x%04h expected=0x%04h",
               req, win, a, bus_rdata, e);
    end
  endtask

  task automatic irq_check(input string req);
    logic e;
    #1;
    e = m_st & alarm_en;
    checks++;
    if (alarm_irq !== e) begin
      fails++;
      $display("FAIL %s alarm_irq actual=%0b expected=%0b", req, alarm_irq, e);
    end
  endtask

  task automatic check_all(input string req);
    rd_check(0, 5'h00, req); rd_check(0, 5'h02, req); rd_check(0, 5'h04, req);
    rd_check(0, 5'h08, req); rd_check(0, 5'h0A, req); rd_check(0, 5'h0C, req);
    rd_check(1, 5'h1E, req);
    irq_check(req);
  endtask

  task automatic set_cnt(input logic [47:0] v);
    cyc(0, 1, 0, 5'h00, v[15:0]);
    cyc(0, 1, 0, 5'h02, v[31:16]);
    cyc(0, 1, 0, 5'h04, v[47:32]);
  endtask

  task automatic set_cmp(input logic [47:0] v);
    cyc(0, 1, 0, 5'h08, v[15:0]);
    cyc(0, 1, 0, 5'h0A, v[31:16]);
    cyc(0, 1, 0, 5'h0C, v[47:32]);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the run completed");
      finish_run();
    end
  end

  initial begin
    logic [4:0]  addrs [10];
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_1234);
    addrs = '{5'h00, 5'h02, 5'h04, 5'h08, 5'h0A, 5'h0C, 5'h1E, 5'h06, 5'h01, 5'h1F};
    checks = 0; fails = 0; done = 0;
    tick_en = 0; bus_win = 0; bus_addr = '0; bus_wen = 0; bus_wdata = '0;
    alarm_en = 1;
    m_cnt = '0; m_cmp = '0; m_st = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: everything cleared by reset
    check_all("R1");

    // R2: counting and holding
    repeat (5) cyc(1, 0, 0, 5'h00, 16'h0);
    cyc(0, 0, 0, 5'h00, 16'h0);
    check_all("R2");

    // R4: single-word write, no advance on the write edge
    cyc(1, 1, 0, 5'h02, 16'hABCD);
    check_all("R4");

    // R3: carry across words, live reads
    set_cnt(48'h0000_FFFF_FFFE);
    cyc(1, 0, 0, 5'h00, 16'h0);
    rd_check(0, 5'h00, "R3");
    cyc(1, 0, 0, 5'h00, 16'h0);
    check_all("R3");

    // R5: compare words
    set_cmp(48'h1234_5678_9ABC);
    check_all("R5");

    // R6: match on the advancing edge, sticky afterwards
    set_cnt(48'h10);
    set_cmp(48'h12);
    cyc(1, 0, 0, 5'h00, 16'h0);
    check_all("R6");
    cyc(1, 0, 0, 5'h00, 16'h0);
    check_all("R6");
    cyc(1, 0, 0, 5'h00, 16'h0);
    check_all("R6");

    // R7: writing 0 keeps it, writing 1 clears it
    cyc(0, 1, 1, 5'h1E, 16'hFFFE);
    check_all("R7");
    // R8: gating by the enable
    alarm_en = 0;
    irq_check("R8");
    alarm_en = 1;
    irq_check("R8");
    cyc(0, 1, 1, 5'h1E, 16'h0001);
    check_all("R7");

    // R7: set wins over clear on the same edge
    set_cnt(48'h40);
    set_cmp(48'h41);
    cyc(1, 1, 1, 5'h1E, 16'h0001);
    check_all("R7");
    cyc(0, 1, 1, 5'h1E, 16'h0001);

    // R6: equality made by writes does not set the status
    set_cmp(48'h77);
    set_cnt(48'h77);
    check_all("R6");

    // R2: wrap from all-ones to zero, matching a zero compare
    set_cmp(48'h0);
    set_cnt(48'hFFFF_FFFF_FFFF);
    cyc(1, 0, 0, 5'h00, 16'h0);
    check_all("R2");
    cyc(0, 1, 1, 5'h1E, 16'h0001);

    // R9: unmapped and odd offsets
    set_cnt(48'h0001_0002_0003);
    cyc(0, 1, 0, 5'h06, 16'hDEAD);
    cyc(0, 1, 0, 5'h01, 16'hBEEF);
    cyc(0, 1, 0, 5'h09, 16'hBEEF);
    cyc(0, 1, 1, 5'h00, 16'hBEEF);
    rd_check(0, 5'h06, "R9");
    rd_check(0, 5'h01, "R9");
    rd_check(1, 5'h00, "R9");
    rd_check(0, 5'h1E, "R9");
    check_all("R9");

    // R3: one-second bit. Seconds 5 -> low 0x8000, mid 0x0002.
    set_cnt({15'h0, 33'd5} << 15);
    rd_check(0, 5'h00, "R3");
    rd_check(0, 5'h02, "R3");
    for (int i = 0; i < 32768; i++) cyc(1, 0, 0, 5'h00, 16'h0);
    check_all("R3");

    // Random traffic with periodic re-aiming of the compare value
    for (int n = 0; n < 3000; n++) begin
      if (n % 150 == 0) set_cmp(m_cnt + 48'($urandom_range(1, 12)));
      alarm_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) begin
        logic [4:0] a;
        bit w;
        a = addrs[$urandom_range(0, 9)];
        w = (a == 5'h1E) ? 1'b1 : ($urandom_range(0, 4) == 0);
        cyc($urandom_range(0, 9) < 7, 1, w, a, 16'($urandom));
      end else begin
        cyc($urandom_range(0, 9) < 7, 0, 0, 5'h00, 16'h0);
      end
      rd_check($urandom_range(0, 1), addrs[$urandom_range(0, 9)], "R2/R5/R6 random");
      rd_check(1, 5'h1E, "R6 random");
      irq_check("R8 random");
    end

    done = 1;
    finish_run();
  end
endmodule